// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block takes an asynchronous serial line and turns each frame into a parallel word. The frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. The serial input passes through a synchronizer. The block then samples the bits using a tick supplied by an external rate divider at 16 times the bit rate.

Finished words go into a two-entry first-in first-out buffer, so the consumer may leave two words unread. If a third frame finishes while both entries are still occupied, a sticky overrun flag is set. While that flag is set, further frames are thrown away. The flag clears only when software turns the receive enable off.

Software works through one 8-bit control/status register and a read strobe for the data word. The status bits describe the word at the head of the buffer, so software reads the status first and then pops the data. A receive-ready flag and a maskable interrupt show when the buffer holds data.

Top module: `uart_rx_dbuf`

## Requirements
- R1: The buffer holds up to two complete words. Words are returned in arrival order, and filling both entries does not set overrun.
- R2: A frame that completes while both entries are unread sets overrun (status bit 5). That frame is discarded, and both stored words stay readable.
- R3: `rx_ready_o` is high exactly while the buffer is non-empty. `irq_o` equals `rx_ready_o` gated by the interrupt-enable bit (control bit 7).
- R4: Control bit 1 selects 9-bit frames, and the ninth received bit is reported in status bit 6. In 8-bit mode, status bit 6 reads 0.
- R5: A stop bit sampled low sets the framing-error bit (status bit 4) for that word, and the word is still stored.
- R6: While overrun is set, arriving frames are discarded and the buffer contents do not change. Writing control bit 2 (receive enable) as 0 clears overrun.
- R7: Nothing is received unless both the port enable (control bit 0) and the receive enable (control bit 2) are set.
- R8: After reset the register reads 0x00 and the buffer is empty. Bit 3 is reserved and always reads 0. Only bits 0, 1, 2 and 7 are writable.
- R9: Each `rd_i` pulse pops the head entry. The data, ninth bit and framing error always describe the head entry. When the buffer is empty these read 0, and a pop has no effect.
- R10: Data is taken least significant bit first, by a majority vote of three samples around each bit centre. A single corrupted sample does not change the bit. A low pulse shorter than half a bit is not taken as a start bit.
- R11: After a frame with a low stop bit, a new start bit is accepted only after the line has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Single-cycle pulse at 16x the bit rate |
| rd_i | input | 1 | Data read strobe; pops the head entry |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| rx_data_o | output | DATA_W | Data of the head entry |
| stat_o | output | 8 | Control/status register readback |
| rx_ready_o | output | 1 | Buffer holds at least one word |
| irq_o | output | 1 | Receive interrupt |

## Verification
The assertions rely on the following properties of the inputs:
- `tick_i` is a pulse one clock wide.
- The control register changes only through `ctl_wr_i`.
- The buffer is never pushed while full, because the overrun logic absorbs a third frame instead of writing it.

The stimulus keeps within these limits. It generates the tick on every second clock, holds every serial bit for exactly 16 ticks, and writes the control register only while the line is idle between frames. The only deliberate departures from clean timing are a short false start and a two-clock glitch inside a data bit. Both are narrower than the half-bit and one-sample windows the receiver is designed to absorb.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  // control/status register bit positions
  localparam int CTL_PEN   = 0;
  localparam int CTL_NINE  = 1;
  localparam int CTL_REN   = 2;
  localparam int CTL_RSV   = 3;
  localparam int ST_FERR   = 4;
  localparam int ST_OVR    = 5;
  localparam int ST_NINTH  = 6;
  localparam int CTL_IRQEN = 7;

  typedef enum logic [2:0] {
    RX_IDLE   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_STOP   = 3'd3,
    RX_WAITHI = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              nine_i,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              frm_vld_o,
  output logic [DATA_W-1:0] frm_data_o,
  output logic              frm_ninth_o,
  output logic              frm_ferr_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;
  localparam int BIT_W = $clog2(DATA_W + 2);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bitn_q, bitn_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic [1:0]        smp_q, smp_d;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ninth_q, ninth_d;
  logic              ferr_q, ferr_d;

  logic             vote;
  logic             bit_end;
  logic [BIT_W-1:0] last_bit;

  assign vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & rx_i) | (smp_q[1] & rx_i);
  assign bit_end  = (cnt_q == CNT_W'(OSR-1));
  assign last_bit = nine_i ? BIT_W'(DATA_W) : BIT_W'(DATA_W-1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bitn_d  = bitn_q;
    sh_d    = sh_q;
    smp_d   = smp_q;
    vld_d   = 1'b0;
    data_d  = data_q;
    ninth_d = ninth_q;
    ferr_d  = ferr_q;
    if (!en_i) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick_i) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_W'(HALF-1)) begin
            cnt_d  = '0;
            bitn_d = '0;
            state_d = rx_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA, RX_STOP: begin
          cnt_d = bit_end ? '0 : cnt_q + 1'b1;
          if (cnt_q == CNT_W'(OSR-3)) smp_d[0] = rx_i;
          if (cnt_q == CNT_W'(OSR-2)) smp_d[1] = rx_i;
          if (bit_end) begin
            if (state_q == RX_DATA) begin
              sh_d = {vote, sh_q[DATA_W:1]};
              if (bitn_q == last_bit) state_d = RX_STOP;
              else                    bitn_d  = bitn_q + 1'b1;
            end else begin
              vld_d   = 1'b1;
              ferr_d  = ~vote;
              data_d  = nine_i ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
              ninth_d = nine_i & sh_q[DATA_W];
              state_d = vote ? RX_IDLE : RX_WAITHI;
            end
          end
        end
        RX_WAITHI: begin
          if (rx_i) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      smp_q   <= '1;
      vld_q   <= 1'b0;
      data_q  <= '0;
      ninth_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bitn_q  <= bitn_d;
      sh_q    <= sh_d;
      smp_q   <= smp_d;
      vld_q   <= vld_d;
      data_q  <= data_d;
      ninth_q <= ninth_d;
      ferr_q  <= ferr_d;
    end
  end

  assign frm_vld_o   = vld_q;
  assign frm_data_o  = data_q;
  assign frm_ninth_o = ninth_q;
  assign frm_ferr_o  = ferr_q;

  // R7
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == RX_IDLE));

  // R5
  vld_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_o |-> ($past(state_q) == RX_STOP));

  // R11
  waithi_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_WAITHI && en_i && !rx_i) |=> (state_q == RX_WAITHI));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [W-1:0]     mem_d [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_eff, pop_eff;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign push_eff = push_i & ~full_o;
  assign pop_eff  = pop_i & ~empty_o;
  assign head_o   = mem_q[rptr_q];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    if (push_eff) mem_d[wptr_q] = wdata_i;
    wptr_d = push_eff ? ptr_inc(wptr_q) : wptr_q;
    rptr_d = pop_eff  ? ptr_inc(rptr_q) : rptr_q;
    case ({push_eff, pop_eff})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R2
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));

  // R9
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [7:0]        stat_o,
  output logic              rx_ready_o,
  output logic              irq_o
);
  localparam int ENT_W = DATA_W + 2;

  logic pen_q, pen_d, nine_q, nine_d, ren_q, ren_d, irqen_q, irqen_d, ovr_q, ovr_d;
  logic rx_s;
  logic frm_vld, frm_ninth, frm_ferr;
  logic [DATA_W-1:0] frm_data;
  logic [ENT_W-1:0]  head;
  logic empty, full, push;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (rx_i), .q_o (rx_s)
  );

  uart_rx_deframer #(.OSR(OSR), .DATA_W(DATA_W)) u_deframer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (pen_q & ren_q),
    .nine_i      (nine_q),
    .tick_i      (tick_i),
    .rx_i        (rx_s),
    .frm_vld_o   (frm_vld),
    .frm_data_o  (frm_data),
    .frm_ninth_o (frm_ninth),
    .frm_ferr_o  (frm_ferr)
  );

  assign push = frm_vld & ~full & ~ovr_q;

  uart_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i ({frm_ferr, frm_ninth, frm_data}),
    .pop_i   (rd_i),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full)
  );

  always_comb begin
    pen_d   = ctl_wr_i ? ctl_wdata_i[CTL_PEN]   : pen_q;
    nine_d  = ctl_wr_i ? ctl_wdata_i[CTL_NINE]  : nine_q;
    ren_d   = ctl_wr_i ? ctl_wdata_i[CTL_REN]   : ren_q;
    irqen_d = ctl_wr_i ? ctl_wdata_i[CTL_IRQEN] : irqen_q;
    ovr_d   = ovr_q;
    if (frm_vld && full) ovr_d = 1'b1;
    if (!ren_d)          ovr_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q   <= 1'b0;
      nine_q  <= 1'b0;
      ren_q   <= 1'b0;
      irqen_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      pen_q   <= pen_d;
      nine_q  <= nine_d;
      ren_q   <= ren_d;
      irqen_q <= irqen_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rx_data_o  = empty ? '0 : head[DATA_W-1:0];
  assign rx_ready_o = ~empty;
  assign irq_o      = rx_ready_o & irqen_q;

  always_comb begin
    stat_o            = '0;
    stat_o[CTL_PEN]   = pen_q;
    stat_o[CTL_NINE]  = nine_q;
    stat_o[CTL_REN]   = ren_q;
    stat_o[ST_FERR]   = ~empty & head[DATA_W+1];
    stat_o[ST_OVR]    = ovr_q;
    stat_o[ST_NINTH]  = ~empty & head[DATA_W];
    stat_o[CTL_IRQEN] = irqen_q;
  end

  // R2
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[ST_OVR]) |-> $past(frm_vld && full));

  // R2
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_OVR] && !(ctl_wr_i && !ctl_wdata_i[CTL_REN])) |=> stat_o[ST_OVR]);

  // R6
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !ctl_wdata_i[CTL_REN]) |=> !stat_o[ST_OVR]);

  // R6
  ovr_hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[ST_OVR] && !rd_i) |=> $stable(rx_data_o));

  // R3
  ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_ready_o) |-> $past(rd_i));
endmodule

// File: tb/uart_rx_dbuf_tb.sv
`timescale 1ns/1ps
module uart_rx_dbuf_tb;
  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx, tick, rd, wr;
  logic [7:0] wdata;
  logic [7:0] data, stat;
  logic       ready, irq;
  int         nvec = 0;
  int         nfail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  uart_rx_dbuf u_dut (
    .clk_i (clk), .rst_ni (rst_n), .rx_i (rx), .tick_i (tick), .rd_i (rd),
    .ctl_wr_i (wr), .ctl_wdata_i (wdata), .rx_data_o (data), .stat_o (stat),
    .rx_ready_o (ready), .irq_o (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // glitch: invert data bit 0 for two clocks near its centre
  task automatic send(input logic [8:0] d, input bit nine, input bit stop, input bit glitch);
    hold(1'b0, BITCLK);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      if (glitch && i == 0) begin
        hold(d[0], 16); hold(~d[0], 2); hold(d[0], BITCLK - 18);
      end else begin
        hold(d[i], BITCLK);
      end
    end
    hold(stop, BITCLK);
    hold(1'b1, 16);
  endtask

  task automatic ctl(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(negedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 stat", stat, 8'h00);
    check("R8 ready", ready, 0);
    check("R9 empty data", data, 0);
    check("R3 irq", irq, 0);

    // R7 disabled combinations
    send(9'h0A5, 0, 1, 0);
    check("R7 all off", ready, 0);
    ctl(8'h01);
    send(9'h0A5, 0, 1, 0);
    check("R7 port only", ready, 0);
    ctl(8'h04);
    send(9'h0A5, 0, 1, 0);
    check("R7 recv only", ready, 0);

    ctl(8'h05);
    // R10 false start shorter than half a bit
    hold(1'b0, 6); hold(1'b1, 3 * BITCLK);
    check("R10 false start", ready, 0);
    pop();
    check("R9 pop on empty", ready, 0);

    // R10 sweep of all bytes, LSB first
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 0, 1, 0);
      check("R3 ready", ready, 1);
      check("R10 data", data, v);
      check("R4 ninth 8bit", stat[6], 0);
      check("R5 ferr clean", stat[4], 0);
      check("R3 irq masked", irq, 0);
      pop();
      check("R9 popped", ready, 0);
    end

    // R10 single sample glitch
    send(9'h03C, 0, 1, 1);
    check("R10 glitch", data, 8'h3C);
    pop();

    // R3 interrupt
    ctl(8'h85);
    send(9'h05A, 0, 1, 0);
    check("R3 irq on", irq, 1);
    pop();
    check("R3 irq off", irq, 0);

    // R4 9-bit sweep
    ctl(8'h07);
    for (int v = 0; v < 512; v += 8) begin
      send(9'(v + 3), 1, 1, 0);
      check("R4 data", data, (v + 3) & 255);
      check("R4 ninth", stat[6], ((v + 3) >> 8) & 1);
      pop();
    end

    // R5 framing error, R11 recovery, R9 head status
    ctl(8'h05);
    send(9'h081, 0, 0, 0);
    check("R5 ferr set", stat[4], 1);
    check("R5 data kept", data, 8'h81);
    send(9'h042, 0, 1, 0);
    check("R9 head ferr", stat[4], 1);
    pop();
    check("R11 next frame", data, 8'h42);
    check("R9 next ferr", stat[4], 0);
    pop();
    check("R9 empty ferr", stat[4], 0);

    ctl(8'h07);
    send(9'h111, 1, 1, 0);
    send(9'h022, 1, 1, 0);
    check("R9 head ninth", stat[6], 1);
    check("R9 head data", data, 8'h11);
    pop();
    check("R9 second ninth", stat[6], 0);
    check("R9 second data", data, 8'h22);
    pop();

    // R1 / R2 / R6 overrun
    ctl(8'h05);
    send(9'h001, 0, 1, 0);
    send(9'h002, 0, 1, 0);
    check("R1 two held", stat[5], 0);
    send(9'h003, 0, 1, 0);
    check("R2 overrun", stat[5], 1);
    send(9'h004, 0, 1, 0);
    check("R6 still ovr", stat[5], 1);
    check("R1 first", data, 8'h01);
    pop();
    check("R1 second", data, 8'h02);
    pop();
    check("R2 third dropped", ready, 0);
    check("R6 sticky", stat[5], 1);
    ctl(8'h01);
    check("R6 cleared", stat[5], 0);
    ctl(8'h05);
    send(9'h077, 0, 1, 0);
    check("R6 resumed", data, 8'h77);
    pop();

    // R8 reserved bits
    ctl(8'hFF);
    check("R8 writable", stat & 8'h8F, 8'h87);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule